// File: doc/BRIEF.md
# Interrupt File Access Router

The router sits between a hart's indirect register access port and a bank of interrupt files. Each request carries the requesting privilege level, a flag marking guest (virtualized) execution, a guest file number, an 8-bit register selector, a flag for a 64-bit access, the write data and the write mask. The router decides whether the access is legal. It works out which interrupt file and which register of that file the access targets. It then forwards the access to the storage as a read-modify-write, in the same cycle as the request.

The storage answers with the old register value in that same cycle. The router registers a response one cycle after every request. The response carries the old value, or an error flag with zero data when the access was refused. A build parameter selects whether the file bank serves machine level (a single file) or supervisor level (file 0 for the host plus guest files). Register storage and priority selection live outside this block.

Top module: `file_acc_router`

## Requirements
- R1: With `MMODE`=1, a request is legal only for privilege code 3 with the guest flag clear, and it targets file 0. Any other privilege code, or a set guest flag, is an error.
- R2: With `MMODE`=0, only privilege code 1 is legal. A legal access with the guest flag clear targets file 0.
- R3: With `MMODE`=0 and the guest flag set, the access targets the file equal to the guest number when that number is nonzero and below `NUM_FILES`. Otherwise it is an error.
- R4: The selector decodes as follows, with the kind code on `fwd_kind_o`: 0x70 is delivery (kind 0), 0x72 is threshold (kind 1) and 0x76 is top identity (kind 2). The range 0x80–0xBF is a pending word (kind 3) and 0xC0–0xFF is an enable word (kind 4). For the two ranges, the selector's low 6 bits give the 32-bit word number.
- R5: For a 64-bit access to a pending or enable word, an odd word number is an error. An even word number is halved before it is presented on `fwd_word_o`.
- R6: A pending or enable word is an error when its index is not implemented. For a 32-bit access that means a word number of `NUM_IDS/32` or more. For a 64-bit access it means a halved number of `NUM_IDS/64` or more.
- R7: Any selector below 0x80 other than 0x70, 0x72 and 0x76 is an error.
- R8: An illegal request does not raise `fwd_valid_o`. One cycle later it yields `rsp_valid_o`=1, `rsp_err_o`=1 and zero data.
- R9: A legal request raises `fwd_valid_o` in the request cycle and passes the write data through unchanged. One cycle later the response has `rsp_err_o`=0 and returns the value on `fwd_rdata_i` from the request cycle. For a 32-bit access the upper half of that value is cleared.
- R10: For a 32-bit access, the upper half of the forwarded write mask is cleared.
- R11: For delivery, only mask bit 0 is forwarded. For threshold, only the low `$clog2(NUM_IDS+1)` mask bits are forwarded.
- R12: For pending or enable word 0, mask bit 0 is cleared, because identity 0 is not writable.
- R13: In reset, and in the cycle after a cycle with no request, `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_priv_i | input | 2 | Privilege code (1 supervisor, 3 machine) |
| req_virt_i | input | 1 | Guest execution flag |
| req_guest_i | input | GUEST_W | Guest file number |
| req_sel_i | input | 8 | Register selector |
| req_wide_i | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| req_wdata_i | input | DW | Write data |
| req_wmask_i | input | DW | Write mask |
| fwd_valid_o | output | 1 | Legal access forwarded to storage |
| fwd_file_o | output | FILE_W | Target interrupt file |
| fwd_kind_o | output | 3 | Register kind code |
| fwd_word_o | output | WORD_W | Pending/enable word index |
| fwd_wdata_o | output | DW | Write data to storage |
| fwd_wmask_o | output | DW | Trimmed write mask to storage |
| fwd_rdata_i | input | DW | Old register value from storage |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | DW | Old value returned |

## Verification
A wrong file mapping or a wrong legality decision shows up in the request cycle itself. It appears either as a forward strobe that should be absent or as the wrong value on `fwd_file_o`, `fwd_kind_o` or `fwd_word_o`. A fault in mask trimming appears on `fwd_wmask_o` in the same cycle. A fault in the response register shows up exactly one cycle later: a missing strobe, a wrong error flag, or data that was not zeroed or not halved. The bench builds a machine-level instance and a supervisor-level instance and drives both with the same stimulus, so every request exercises both legality rule sets.

// File: rtl/file_acc_pkg.sv
package file_acc_pkg;
  localparam int SEL_W = 8;

  typedef enum logic [2:0] {
    K_DELIV  = 3'd0,
    K_THRESH = 3'd1,
    K_TOP    = 3'd2,
    K_PEND   = 3'd3,
    K_ENAB   = 3'd4
  } reg_kind_e;

  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [SEL_W-1:0] SEL_DELIV  = 8'h70;
  localparam logic [SEL_W-1:0] SEL_THRESH = 8'h72;
  localparam logic [SEL_W-1:0] SEL_TOP    = 8'h76;
endpackage

// File: rtl/acc_file_sel.sv
module acc_file_sel #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_FILES = 8,
  parameter int GUEST_W   = 6,
  parameter int FILE_W    = 3
) (
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [GUEST_W-1:0] guest_i,
  output logic               ok_o,
  output logic [FILE_W-1:0]  file_o
);
  import file_acc_pkg::*;

  localparam logic [GUEST_W:0] FILES_LIM = NUM_FILES[GUEST_W:0];

  always_comb begin
    ok_o   = 1'b0;
    file_o = '0;
    if (MMODE) begin
      ok_o = (priv_i == PRIV_M) && !virt_i;
    end else if (priv_i == PRIV_S) begin
      if (!virt_i) begin
        ok_o = 1'b1;
      end else if ((guest_i != '0) && ({1'b0, guest_i} < FILES_LIM)) begin
        ok_o   = 1'b1;
        file_o = guest_i[FILE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/acc_reg_decode.sv
module acc_reg_decode #(
  parameter int NUM_IDS = 256,
  parameter int DW      = 64,
  parameter int ID_W    = 9,
  parameter int WORD_W  = 3
) (
  input  logic [file_acc_pkg::SEL_W-1:0] sel_i,
  input  logic                           wide_i,
  input  logic [DW-1:0]                  wmask_i,
  output logic                           ok_o,
  output file_acc_pkg::reg_kind_e        kind_o,
  output logic [WORD_W-1:0]              word_o,
  output logic [DW-1:0]                  wmask_o
);
  import file_acc_pkg::*;

  localparam int HALF = DW / 2;
  localparam logic [6:0] W32_LIM = 7'(NUM_IDS / 32);
  localparam logic [6:0] W64_LIM = 7'(NUM_IDS / 64);
  localparam logic [DW-1:0] DELIV_KEEP = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] THR_KEEP   = {{(DW-ID_W){1'b0}}, {ID_W{1'b1}}};

  logic [DW-1:0] narrow_mask;
  logic [5:0]    w32;
  logic [5:0]    idx;

  assign narrow_mask = wide_i ? wmask_i : {{(DW-HALF){1'b0}}, wmask_i[HALF-1:0]};
  assign w32         = sel_i[5:0];

  always_comb begin
    ok_o    = 1'b0;
    kind_o  = K_DELIV;
    idx     = '0;
    wmask_o = narrow_mask;
    if (sel_i == SEL_DELIV) begin
      ok_o    = 1'b1;
      wmask_o = narrow_mask & DELIV_KEEP;
    end else if (sel_i == SEL_THRESH) begin
      ok_o    = 1'b1;
      kind_o  = K_THRESH;
      wmask_o = narrow_mask & THR_KEEP;
    end else if (sel_i == SEL_TOP) begin
      ok_o   = 1'b1;
      kind_o = K_TOP;
    end else if (sel_i[7]) begin
      kind_o = sel_i[6] ? K_ENAB : K_PEND;
      if (wide_i) begin
        idx  = {1'b0, w32[5:1]};
        ok_o = !w32[0] && ({1'b0, idx} < W64_LIM);
      end else begin
        idx  = w32;
        ok_o = {1'b0, idx} < W32_LIM;
      end
      if (idx == '0) wmask_o[0] = 1'b0;  // identity 0 is not writable
    end
  end

  assign word_o = idx[WORD_W-1:0];
endmodule

// File: rtl/acc_rsp_reg.sv
module acc_rsp_reg #(
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          err_i,
  input  logic          wide_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] rdata_d;

  always_comb begin
    if (err_i)       rdata_d = '0;
    else if (wide_i) rdata_d = rdata_i;
    else             rdata_d = {{(DW-HALF){1'b0}}, rdata_i[HALF-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i && err_i;
      rdata_o <= valid_i ? rdata_d : '0;
    end
  end
endmodule

// File: rtl/file_acc_router.sv
module file_acc_router #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_FILES = 8,
  parameter int GUEST_W   = 6,
  parameter int NUM_IDS   = 256,
  parameter int DW        = 64,
  localparam int FILE_W   = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1,
  localparam int WORD_W   = $clog2(NUM_IDS / 32),
  localparam int ID_W     = $clog2(NUM_IDS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic [1:0]                     req_priv_i,
  input  logic                           req_virt_i,
  input  logic [GUEST_W-1:0]             req_guest_i,
  input  logic [file_acc_pkg::SEL_W-1:0] req_sel_i,
  input  logic                           req_wide_i,
  input  logic [DW-1:0]                  req_wdata_i,
  input  logic [DW-1:0]                  req_wmask_i,
  output logic                           fwd_valid_o,
  output logic [FILE_W-1:0]              fwd_file_o,
  output file_acc_pkg::reg_kind_e        fwd_kind_o,
  output logic [WORD_W-1:0]              fwd_word_o,
  output logic [DW-1:0]                  fwd_wdata_o,
  output logic [DW-1:0]                  fwd_wmask_o,
  input  logic [DW-1:0]                  fwd_rdata_i,
  output logic                           rsp_valid_o,
  output logic                           rsp_err_o,
  output logic [DW-1:0]                  rsp_rdata_o
);
  logic file_ok;
  logic reg_ok;
  logic legal;

  acc_file_sel #(
    .MMODE    (MMODE),
    .NUM_FILES(NUM_FILES),
    .GUEST_W  (GUEST_W),
    .FILE_W   (FILE_W)
  ) u_file_sel (
    .priv_i (req_priv_i),
    .virt_i (req_virt_i),
    .guest_i(req_guest_i),
    .ok_o   (file_ok),
    .file_o (fwd_file_o)
  );

  acc_reg_decode #(
    .NUM_IDS(NUM_IDS),
    .DW     (DW),
    .ID_W   (ID_W),
    .WORD_W (WORD_W)
  ) u_reg_decode (
    .sel_i  (req_sel_i),
    .wide_i (req_wide_i),
    .wmask_i(req_wmask_i),
    .ok_o   (reg_ok),
    .kind_o (fwd_kind_o),
    .word_o (fwd_word_o),
    .wmask_o(fwd_wmask_o)
  );

  assign legal       = file_ok && reg_ok;
  assign fwd_valid_o = req_valid_i && legal;
  assign fwd_wdata_o = req_wdata_i;

  acc_rsp_reg #(
    .DW(DW)
  ) u_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(req_valid_i),
    .err_i  (!legal),
    .wide_i (req_wide_i),
    .rdata_i(fwd_rdata_i),
    .valid_o(rsp_valid_o),
    .err_o  (rsp_err_o),
    .rdata_o(rsp_rdata_o)
  );
endmodule

// File: rtl/file_acc_router_chk.sv
module file_acc_router_chk #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_FILES = 8,
  parameter int GUEST_W   = 6,
  parameter int NUM_IDS   = 256,
  parameter int DW        = 64,
  localparam int FILE_W   = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1,
  localparam int WORD_W   = $clog2(NUM_IDS / 32)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [1:0]              req_priv_i,
  input logic                    req_virt_i,
  input logic                    req_wide_i,
  input logic                    fwd_valid_o,
  input logic [FILE_W-1:0]       fwd_file_o,
  input file_acc_pkg::reg_kind_e fwd_kind_o,
  input logic [WORD_W-1:0]       fwd_word_o,
  input logic [DW-1:0]           fwd_wmask_o,
  input logic [DW-1:0]           fwd_rdata_i,
  input logic                    rsp_valid_o,
  input logic                    rsp_err_o,
  input logic [DW-1:0]           rsp_rdata_o
);
  import file_acc_pkg::*;

  // R1
  mmode_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MMODE && fwd_valid_o) |-> (req_priv_i == PRIV_M) && !req_virt_i);

  // R2
  host_file_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !req_virt_i) |-> (fwd_file_o == '0));

  // R8
  refuse_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !fwd_valid_o) |=> rsp_valid_o && rsp_err_o && (rsp_rdata_o == '0));

  // R9
  wide_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && req_wide_i) |=> rsp_valid_o && !rsp_err_o &&
                                    (rsp_rdata_o == $past(fwd_rdata_i)));

  // R10
  narrow_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !req_wide_i) |-> (fwd_wmask_o[DW-1:DW/2] == '0));

  // R12
  word0_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && (fwd_kind_o == K_PEND || fwd_kind_o == K_ENAB) && fwd_word_o == '0)
      |-> !fwd_wmask_o[0]);

  // R13
  idle_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
endmodule

bind file_acc_router file_acc_router_chk #(
  .MMODE    (MMODE),
  .NUM_FILES(NUM_FILES),
  .GUEST_W  (GUEST_W),
  .NUM_IDS  (NUM_IDS),
  .DW       (DW)
) u_chk (.*);

// File: tb/sim_file_acc_router.sv
module sim_file_acc_router;
  localparam int NF = 8;
  localparam int GW = 6;
  localparam int NI = 256;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          valid = 1'b0;
  logic [1:0]    priv = '0;
  logic          virt = 1'b0;
  logic [GW-1:0] guest = '0;
  logic [7:0]    sel = '0;
  logic          wide = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] wmask = '0;

  logic          fv[2];
  logic [2:0]    ffile[2];
  logic [2:0]    fkind[2];
  logic [2:0]    fword[2];
  logic [DW-1:0] fwdat[2];
  logic [DW-1:0] fmask[2];
  logic [DW-1:0] rd[2];
  logic          rv[2];
  logic          re[2];
  logic [DW-1:0] rdat[2];

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] stor(input logic [2:0] f, input logic [2:0] k, input logic [2:0] w);
    return {8'hA5, 5'd0, f, 5'd0, k, 5'd0, w, 8'h3C, 5'd0, w, 5'd0, k, 5'd0, f};
  endfunction

  always_comb for (int m = 0; m < 2; m++) rd[m] = stor(ffile[m], fkind[m], fword[m]);

  file_acc_router #(.MMODE(1'b0), .NUM_FILES(NF), .GUEST_W(GW), .NUM_IDS(NI), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_priv_i(priv), .req_virt_i(virt),
    .req_guest_i(guest), .req_sel_i(sel), .req_wide_i(wide), .req_wdata_i(wdata),
    .req_wmask_i(wmask), .fwd_valid_o(fv[0]), .fwd_file_o(ffile[0]), .fwd_kind_o(fkind[0]),
    .fwd_word_o(fword[0]), .fwd_wdata_o(fwdat[0]), .fwd_wmask_o(fmask[0]), .fwd_rdata_i(rd[0]),
    .rsp_valid_o(rv[0]), .rsp_err_o(re[0]), .rsp_rdata_o(rdat[0]));

  file_acc_router #(.MMODE(1'b1), .NUM_FILES(NF), .GUEST_W(GW), .NUM_IDS(NI), .DW(DW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_priv_i(priv), .req_virt_i(virt),
    .req_guest_i(guest), .req_sel_i(sel), .req_wide_i(wide), .req_wdata_i(wdata),
    .req_wmask_i(wmask), .fwd_valid_o(fv[1]), .fwd_file_o(ffile[1]), .fwd_kind_o(fkind[1]),
    .fwd_word_o(fword[1]), .fwd_wdata_o(fwdat[1]), .fwd_wmask_o(fmask[1]), .fwd_rdata_i(rd[1]),
    .rsp_valid_o(rv[1]), .rsp_err_o(re[1]), .rsp_rdata_o(rdat[1]));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected routing from the requirements; m=1 is the machine-level build.
  task automatic expect_route(input int m, output bit ok, output logic [2:0] ef,
                              output logic [2:0] ek, output logic [2:0] ew,
                              output logic [DW-1:0] em);
    bit fok = 0;
    bit rok = 0;
    int off;
    int w = 0;
    logic [DW-1:0] nm;
    ef = 0; ek = 0;
    if (m == 1) fok = (priv == 2'd3) && !virt;                 // R1
    else if (priv == 2'd1) begin                               // R2
      if (!virt) fok = 1;
      else if (guest != 0 && guest < NF) begin fok = 1; ef = guest[2:0]; end  // R3
    end
    nm = wide ? wmask : {32'd0, wmask[31:0]};                  // R10
    em = nm;
    if (sel == 8'h70) begin rok = 1; ek = 0; em = nm & 64'h1; end        // R11
    else if (sel == 8'h72) begin rok = 1; ek = 1; em = nm & 64'h1FF; end // R11
    else if (sel == 8'h76) begin rok = 1; ek = 2; end
    else if (sel >= 8'h80) begin                               // R4
      ek = (sel >= 8'hC0) ? 3'd4 : 3'd3;
      off = int'(sel) % 64;
      if (wide) begin w = off / 2; rok = (off % 2 == 0) && (w < NI / 64); end  // R5 R6
      else begin w = off; rok = off < NI / 32; end                             // R6
      if (w == 0) em[0] = 1'b0;                                               // R12
    end                                                        // else R7
    ew = 3'(w);
    ok = fok && rok;
  endtask

  task automatic do_req(input logic [1:0] p, input logic v, input logic [GW-1:0] g,
                        input logic [7:0] s, input logic wd, input logic [DW-1:0] d,
                        input logic [DW-1:0] mk);
    bit eok[2];
    logic [DW-1:0] erd[2];
    logic [2:0] ef, ek, ew;
    logic [DW-1:0] em, full;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      chk(rv[m] == 1'b0, $sformatf("R13 idle rsp_valid m%0d", m), 64'(rv[m]), 0);
    valid = 1; priv = p; virt = v; guest = g; sel = s; wide = wd; wdata = d; wmask = mk;
    #1;
    for (int m = 0; m < 2; m++) begin
      expect_route(m, eok[m], ef, ek, ew, em);
      chk(fv[m] == eok[m], $sformatf("R8 fwd_valid m%0d sel=%h", m, s), 64'(fv[m]), 64'(eok[m]));
      erd[m] = '0;
      if (eok[m]) begin
        chk(ffile[m] == ef, $sformatf("R3 file m%0d", m), 64'(ffile[m]), 64'(ef));
        chk(fkind[m] == ek, $sformatf("R4 kind m%0d", m), 64'(fkind[m]), 64'(ek));
        if (ek >= 3) chk(fword[m] == ew, $sformatf("R5 word m%0d", m), 64'(fword[m]), 64'(ew));
        chk(fmask[m] == em, $sformatf("R10 mask m%0d", m), fmask[m], em);
        chk(fwdat[m] == d, $sformatf("R9 wdata m%0d", m), fwdat[m], d);
        full = stor(ef, ek, (ek >= 3) ? ew : fword[m]);
        erd[m] = wd ? full : {32'd0, full[31:0]};
      end
    end
    @(negedge clk);
    valid = 0;
    for (int m = 0; m < 2; m++) begin
      chk(rv[m] == 1'b1, $sformatf("R9 rsp_valid m%0d", m), 64'(rv[m]), 1);
      chk(re[m] == !eok[m], $sformatf("R8 rsp_err m%0d", m), 64'(re[m]), 64'(!eok[m]));
      chk(rdat[m] == erd[m], $sformatf("R9 rsp_rdata m%0d", m), rdat[m], erd[m]);
    end
  endtask

  localparam logic [DW-1:0] ONES = '1;

  initial begin
    void'($urandom(32'd20240607));
    #23;
    for (int m = 0; m < 2; m++)
      chk(rv[m] == 0 && re[m] == 0, $sformatf("R13 reset rsp m%0d", m), 64'(rv[m]), 0);
    rst_n = 1'b1;
    // R1 R2: machine vs supervisor privilege
    do_req(2'd3, 0, 0, 8'h70, 0, 64'h1234, ONES);
    do_req(2'd1, 0, 0, 8'h72, 1, 64'h5678, ONES);  // R11 threshold trim
    do_req(2'd3, 1, 2, 8'h70, 1, 64'h1, ONES);      // R1 virt refused
    do_req(2'd0, 0, 0, 8'h76, 0, 64'h2, ONES);
    // R3 guest files
    do_req(2'd1, 1, 3, 8'h76, 1, 64'h3, ONES);
    do_req(2'd1, 1, 0, 8'h76, 1, 64'h3, ONES);
    do_req(2'd1, 1, 7, 8'h70, 1, 64'h3, ONES);
    do_req(2'd1, 1, 8, 8'h70, 1, 64'h3, ONES);
    // R12 R10 word 0, narrow and wide
    do_req(2'd1, 0, 0, 8'h80, 0, 64'hFF, ONES);
    do_req(2'd3, 0, 0, 8'hC0, 1, 64'hFF, ONES);
    // R6 range edges
    do_req(2'd1, 0, 0, 8'hC7, 0, 64'h7, ONES);
    do_req(2'd1, 0, 0, 8'hC8, 0, 64'h7, ONES);
    // R5 wide odd / halved / beyond
    do_req(2'd1, 0, 0, 8'h81, 1, 64'h7, ONES);
    do_req(2'd1, 0, 0, 8'h86, 1, 64'h7, ONES);
    do_req(2'd3, 0, 0, 8'h88, 1, 64'h7, ONES);
    // R7 unknown selectors
    do_req(2'd1, 0, 0, 8'h71, 0, 64'h0, ONES);
    do_req(2'd3, 0, 0, 8'h00, 0, 64'h0, ONES);
    do_req(2'd1, 0, 0, 8'h7F, 1, 64'h0, ONES);
    for (int i = 0; i < 600; i++) begin
      logic [7:0] s;
      logic [GW-1:0] g;
      int r = $urandom % 4;
      if (r == 0) begin
        int t = $urandom % 3;
        s = (t == 0) ? 8'h70 : (t == 1) ? 8'h72 : 8'h76;
      end else if (r == 3) s = 8'($urandom);
      else s = 8'h80 + 8'($urandom % 128);
      g = ($urandom % 4 == 0) ? GW'($urandom) : GW'($urandom % 9);
      do_req(2'($urandom), 1'($urandom), g, s, 1'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom});
    end
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule